// File: doc/BRIEF.md
# Delay Measurement Search Controller

This controller measures the delay of an external path by steering two programmable delay lines and watching one sampled bit. Each trial fires both lines from the same launch pulse. The reference line is held at its minimum setting and drives the path under test. The probe line is loaded with a 10-bit code, and its output clocks a flip-flop that samples the path's output. A sampled high means the probe edge came too late, so the code must fall. A sampled low means it came too early, so the code must rise.

The controller runs in two phases. A successive-approximation pass sets each code bit from the most significant down, deciding each bit by a majority vote over several trials. A fine walk then steps the code one count at a time until it finds a code whose trials give both a high and a low result. That dithering code is the measured delay, in probe steps. The controller reports it with a one-cycle completion pulse. It flags a failure if the code would leave the code range, or if no dithering code appears within a bounded number of steps.

Top module: `dly_meas_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o, trig_o and ref_min_o are all low.
- R2: ref_min_o is high from the cycle after an accepted start until completion, and it is high on every trigger pulse.
- R3: After any change of probe_code_o, at least SETTLE clock cycles pass before the next trig_o pulse.
- R4: Each trig_o pulse is a single cycle. No further pulse is issued until sample_vld_i has delivered the result of the previous trial.
- R5: The first trial of a measurement uses code 512: only the most significant bit is set.
- R6: With a path whose sampled bit reads high above code D, low below D and alternates at D, the reported result is D. This holds for D at 0, at 1023 and at interior values.
- R7: Each code evaluation takes exactly VOTES trials (default 5). A run that ends at a range limit after the coarse pass therefore uses 11*VOTES trials in total.
- R8: Completion is a done_o pulse exactly one cycle long. busy_o is low in that cycle, and result_o holds the code until the next completion.
- R9: If the fine walk would step below code 0 or above code 1023, done_o is raised together with err_o.
- R10: If no code with mixed results is found after 8 single-step moves, done_o is raised together with err_o. A path that never dithers uses 19*VOTES trials in total.
- R11: A start_i pulse while busy_o is high has no effect on the running measurement's result or trial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement (taken only when idle) |
| trig_o | output | 1 | One-cycle launch pulse for both delay lines |
| probe_code_o | output | 10 | Code applied to the probe delay line |
| ref_min_o | output | 1 | Forces the reference delay line to its minimum |
| sample_i | input | 1 | Sampled bit from the flip-flop |
| sample_vld_i | input | 1 | sample_i is valid for the last trial |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Measured code |
| err_o | output | 1 | Set with done_o when the search failed |

## Verification
The main stimulus is a modelled path with a dithering edge. The edge is placed at 0, 1, 511, 512, 777 and 1023. These positions separate a correct bit ordering and vote direction from an inverted one, and they exercise both ends of the code range. A bit stuck high and a bit stuck low drive the fine walk into each range limit. Their trial counts expose a wrong vote length. A path with a hard threshold and no dither makes the walk oscillate until the move limit, which its exact trial count confirms. A start pulse in mid-run and a reset in mid-run show that the running search is left alone and that reset returns the block to idle.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_TRIG,
    ST_WAIT,
    ST_CHECK
  } dm_state_e;
endpackage

// File: rtl/dm_settle_timer.sv
module dm_settle_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  generate
    if (SETTLE == 0) begin : g_none
      assign expired_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(SETTLE + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (load_i)    cnt_q <= CW'(SETTLE);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      end
      assign expired_o = (cnt_q == '0) && !load_i;
    end
  endgenerate
endmodule

// File: rtl/dm_vote_acc.sv
module dm_vote_acc #(
  parameter int VOTES = 5,
  localparam int VW = $clog2(VOTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic          bit_i,
  output logic [VW-1:0] ones_o,
  output logic [VW-1:0] zeros_o,
  output logic          full_o
);
  logic [VW-1:0] ones_q, zeros_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      zeros_q <= '0;
      total_q <= '0;
    end else if (clr_i) begin
      ones_q  <= '0;
      zeros_q <= '0;
      total_q <= '0;
    end else if (add_i) begin
      if (bit_i) ones_q  <= ones_q + 1'b1;
      else       zeros_q <= zeros_q + 1'b1;
      total_q <= total_q + 1'b1;
    end
  end

  assign ones_o  = ones_q;
  assign zeros_o = zeros_q;
  assign full_o  = (total_q == VW'(VOTES));
endmodule

// File: rtl/dly_meas_ctrl.sv
module dly_meas_ctrl
  import dm_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int VOTES     = 5,
  parameter int SETTLE    = 4,
  parameter int MAX_MOVES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              trig_o,
  output logic [CODE_W-1:0] probe_code_o,
  output logic              ref_min_o,
  input  logic              sample_i,
  input  logic              sample_vld_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              err_o
);
  localparam int VW = $clog2(VOTES + 1);
  localparam int MW = $clog2(MAX_MOVES + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] MSB_MASK = CODE_W'(1) << (CODE_W - 1);

  dm_state_e         state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] mask_q, mask_d;
  logic [CODE_W-1:0] result_q, result_d;
  logic [MW-1:0]     moves_q, moves_d;
  logic              fine_q, fine_d;
  logic              refmin_q, refmin_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic [VW-1:0]     ones, zeros;
  logic              vote_full, vote_clr, vote_add;
  logic              settle_load, settle_exp;
  logic              maj_hi;
  logic [CODE_W-1:0] coarse_code;

  dm_vote_acc #(.VOTES(VOTES)) i_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vote_clr),
    .add_i  (vote_add),
    .bit_i  (sample_i),
    .ones_o (ones),
    .zeros_o(zeros),
    .full_o (vote_full)
  );

  dm_settle_timer #(.SETTLE(SETTLE)) i_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (settle_load),
    .expired_o(settle_exp)
  );

  // high majority: probe too late, drop the trial bit
  assign maj_hi      = (int'(ones) * 2) > VOTES;
  assign coarse_code = maj_hi ? (code_q & ~mask_q) : code_q;

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    mask_d   = mask_q;
    result_d = result_q;
    moves_d  = moves_q;
    fine_d   = fine_q;
    refmin_d = refmin_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    vote_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_SETTLE;
          code_d   = MSB_MASK;
          mask_d   = MSB_MASK;
          moves_d  = '0;
          fine_d   = 1'b0;
          refmin_d = 1'b1;
          vote_clr = 1'b1;
        end
      end
      ST_SETTLE: if (settle_exp) state_d = ST_TRIG;
      ST_TRIG:   state_d = ST_WAIT;
      ST_WAIT:   if (sample_vld_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!vote_full) begin
          state_d = ST_TRIG;
        end else begin
          vote_clr = 1'b1;
          state_d  = ST_SETTLE;
          if (!fine_q) begin
            if (mask_q[0]) begin
              fine_d = 1'b1;
              code_d = coarse_code;
            end else begin
              mask_d = mask_q >> 1;
              code_d = coarse_code | (mask_q >> 1);
            end
          end else if (ones != '0 && zeros != '0) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = code_q;
            refmin_d = 1'b0;
          end else if (zeros == '0) begin
            if (code_q == '0 || moves_q == MW'(MAX_MOVES)) begin
              state_d  = ST_IDLE;
              done_d   = 1'b1;
              err_d    = 1'b1;
              result_d = code_q;
              refmin_d = 1'b0;
            end else begin
              code_d  = code_q - 1'b1;
              moves_d = moves_q + 1'b1;
            end
          end else begin
            if (code_q == CODE_MAX || moves_q == MW'(MAX_MOVES)) begin
              state_d  = ST_IDLE;
              done_d   = 1'b1;
              err_d    = 1'b1;
              result_d = code_q;
              refmin_d = 1'b0;
            end else begin
              code_d  = code_q + 1'b1;
              moves_d = moves_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign vote_add    = (state_q == ST_WAIT) && sample_vld_i;
  assign settle_load = (state_d == ST_SETTLE) && (state_q != ST_SETTLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      mask_q   <= '0;
      result_q <= '0;
      moves_q  <= '0;
      fine_q   <= 1'b0;
      refmin_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_d;
      mask_q   <= mask_d;
      result_q <= result_d;
      moves_q  <= moves_d;
      fine_q   <= fine_d;
      refmin_q <= refmin_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign trig_o       = (state_q == ST_TRIG);
  assign probe_code_o = code_q;
  assign ref_min_o    = refmin_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign result_o     = result_q;
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
  parameter int CODE_W = 10,
  parameter int SETTLE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_o,
  input logic [CODE_W-1:0] probe_code_o,
  input logic              ref_min_o,
  input logic              sample_vld_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int GW = $clog2(SETTLE + 2);
  logic [GW-1:0]     gap_q;
  logic [CODE_W-1:0] prev_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= probe_code_o;
      if (probe_code_o != prev_q)    gap_q <= '0;
      else if (gap_q < GW'(SETTLE))  gap_q <= gap_q + 1'b1;
      if (trig_o)            pend_q <= 1'b1;
      else if (sample_vld_i) pend_q <= 1'b0;
    end
  end

  assert_refmin_on_trig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ref_min_o);
  assert_settled_trig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (gap_q >= GW'(SETTLE)));
  assert_one_outstanding_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !pend_q);
  assert_trig_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_err_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind dly_meas_ctrl dm_checker #(.CODE_W(CODE_W), .SETTLE(SETTLE)) i_dm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_o      (trig_o),
  .probe_code_o(probe_code_o),
  .ref_min_o   (ref_min_o),
  .sample_vld_i(sample_vld_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_dly_meas_ctrl.sv
`timescale 1ns/1ps
module test_dly_meas_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic       sample = 1'b0, sample_vld = 1'b0;
  logic       trig, ref_min, busy, done, err;
  logic [9:0] code, result;

  dly_meas_ctrl i_dly_meas_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trig_o(trig),
    .probe_code_o(code), .ref_min_o(ref_min), .sample_i(sample),
    .sample_vld_i(sample_vld), .busy_o(busy), .done_o(done),
    .result_o(result), .err_o(err)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int model_mode = 0, model_d = 0;
  logic dith = 1'b0;
  int trig_cnt = 0, first_code = -1, refmin_bad = 0;

  // mode 0: dither at D, 1: stuck high, 2: stuck low, 3: hard threshold at D
  localparam int NV = 10;
  localparam int    V_MODE[NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 3};
  localparam int    V_D[NV]    = '{300, 0, 1023, 512, 511, 1, 777, 0, 0, 200};
  localparam int    V_ERR[NV]  = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1};
  localparam int    V_RES[NV]  = '{300, 0, 1023, 512, 511, 1, 777, -1, -1, -1};
  localparam int    V_TRG[NV]  = '{-1, -1, -1, -1, -1, -1, -1, 55, 55, 95};
  localparam string V_TAG[NV]  = '{"R6", "R6", "R6", "R6", "R6", "R6", "R6",
                                   "R9", "R9", "R10"};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // path model: answers each trigger two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (trig && rst_n) begin
        int c;
        c = int'(code);
        trig_cnt++;
        if (first_code < 0) first_code = c;
        if (!ref_min) refmin_bad++;
        repeat (2) @(negedge clk);
        case (model_mode)
          1: sample = 1'b1;
          2: sample = 1'b0;
          3: sample = (c > model_d);
          default: begin
            if (c > model_d)      sample = 1'b1;
            else if (c < model_d) sample = 1'b0;
            else begin dith = ~dith; sample = dith; end
          end
        endcase
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary_and_end();
  end

  task automatic run_case(input int mode, input int d, input int exp_err, input int exp_res,
                          input int exp_trg, input string tag, input bit poke, output int trigs);
    bit seen, poked;
    seen = 0; poked = 0;
    model_mode = mode; model_d = d; dith = 1'b0;
    trig_cnt = 0; first_code = -1; refmin_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 ref_min after start", int'(ref_min), 1);
    for (int k = 0; k < 20000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
      else begin
        start = poke && !poked && trig_cnt == 7;
        if (start) poked = 1;
      end
    end
    start = 1'b0;
    chk({tag, " done seen"}, int'(seen), 1);
    chk({tag, " err"}, int'(err), exp_err);
    chk("R8 busy low at done", int'(busy), 0);
    if (exp_res >= 0) chk({tag, " result"}, int'(result), exp_res);
    if (exp_trg >= 0) chk({tag, " R7 trial count"}, trig_cnt, exp_trg);
    chk("R5 first code", first_code, 512);
    chk("R2 ref_min on triggers", refmin_bad, 0);
    trigs = trig_cnt;
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    chk("R2 ref_min dropped", int'(ref_min), 0);
    if (exp_res >= 0) begin
      repeat (3) @(negedge clk);
      chk("R8 result held", int'(result), exp_res);
    end
  endtask

  initial begin
    int t_ref, t_poke, t_dummy;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 trig", int'(trig), 0);
    chk("R1 ref_min", int'(ref_min), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      run_case(V_MODE[i], V_D[i], V_ERR[i], V_RES[i], V_TRG[i], V_TAG[i], 1'b0, t_dummy);
    end

    // R11: start in mid-run must not change result or trial count
    run_case(0, 300, 0, 300, -1, "R11", 1'b0, t_ref);
    run_case(0, 300, 0, 300, -1, "R11", 1'b1, t_poke);
    chk("R11 trial count unchanged", t_poke, t_ref);

    // R1: reset in mid-run returns to idle
    model_mode = 0; model_d = 600; dith = 1'b0; trig_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 5000 && trig_cnt < 3; k++) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after mid reset", int'(busy), 0);
    chk("R1 ref_min after mid reset", int'(ref_min), 0);
    chk("R1 done after mid reset", int'(done), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run_case(0, 600, 0, 600, -1, "R6", 1'b0, t_dummy);

    summary_and_end();
  end
endmodule